// File: doc/BRIEF.md
# Tile Row Integer-to-Float Converter

This block holds a small two-dimensional tile and, on request, pulls one 64-byte segment of one tile row out as a 512-bit vector. Each of the sixteen 32-bit lanes in that segment is read as a signed integer and converted to an IEEE single-precision float. Rounding is always round-to-nearest-even, and no exception flags are produced. The tile has sixteen rows of 64 bytes. A write port loads a whole row at a time. A width register sets how many bytes of each row are active, and lanes beyond that width come out as zero.

A request carries a 32-bit selector. Its low half picks the row. Its high half is a chunk number, and the chunk number times 64 gives the byte offset into the row. The result appears on a register one cycle after the request, together with a valid strobe. The result stays unchanged until the next request.

Top module: `tile_row_i2f`

## Requirements
- R1: While reset is held (`rst_n` low at a rising edge), `res_valid` and `res_data` become zero and the active width becomes 64 bytes.
- R2: `res_valid` is high in exactly the cycle after a cycle with `req_valid` high. When no request is made, `res_data` keeps its previous value.
- R3: The row index is `req_sel[15:0]`. A row index of 16 or more gives an all-zero `res_data`.
- R4: The chunk number is `req_sel[31:16]`. Lane i reads the source dword at position chunk*16 + i of the row. A dword position of 16 or more lies outside the row, so any nonzero chunk gives an all-zero vector.
- R5: Lane i is zero when chunk*16 + i is at least floor(width/4). A width above 64 acts as 64, and a width below 4 zeroes every lane.
- R6: Each active lane holds the fp32 encoding of its signed 32-bit source value, rounded to nearest with ties to even. Values of magnitude up to 2^24 are exact.
- R7: Integer 0 gives 0x00000000 (+0.0). -2^31 gives 0xCF000000. 2^31-1 gives 0x4F000000. 2^24+1 gives 0x4B800000 and 2^24+3 gives 0x4B800002 (ties to even).
- R8: With `wr_en` high, `wr_data` replaces row `wr_row` at the clock edge. Lane i of a row is `wr_data[32*i+31:32*i]`.
- R9: With `cfg_we` high, `cfg_width` becomes the active width at the clock edge. A request in the same cycle still uses the old width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Row write enable |
| wr_row | input | 4 | Row written |
| wr_data | input | 512 | Row contents, lane i at bits 32i+31:32i |
| cfg_we | input | 1 | Width register load enable |
| cfg_width | input | 7 | Active row width in bytes |
| req_valid | input | 1 | Conversion request |
| req_sel | input | 32 | Selector: [15:0] row, [31:16] chunk |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| res_data | output | 512 | Converted lanes, lane i at bits 32i+31:32i |

## Verification
The checker watches four things on every cycle: the one-cycle strobe timing, that the result holds between requests, that out-of-range rows and nonzero chunks give zero, and the per-lane zeroing against the current width register. The numeric correctness of the conversion cannot be shown by these properties. Rounding ties, the exact -2^31 case and row write contents are shown only by the bench. The bench sweeps every row index including out-of-range ones, several chunks and widths, and compares each lane with an fp32 value it computes by integer division and remainder.

// File: rtl/tile_cvt_pkg.sv
// Shared types for the tile row converter.
// Assumes 32-bit lanes; the selector packs the chunk number in its upper half.
package tile_cvt_pkg;
    localparam int DW = 32;

    typedef logic [DW-1:0] dword_t;

    // Selector layout: chunk number above, row index below.
    typedef struct packed {
        logic [15:0] chunk;
        logic [15:0] row;
    } sel_t;
endpackage

// File: rtl/tile_row_store.sv
// Row-wide register file holding the tile.
// Writes one full row per cycle; read is combinational. Contents are not reset.
module tile_row_store #(
    parameter int ROWS      = 16,
    parameter int ROW_BYTES = 64,
    localparam int ROW_W    = $clog2(ROWS),
    localparam int DATA_W   = ROW_BYTES * 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] rows_q [ROWS];

    // Store a full row on write enable.
    always_ff @(posedge clk) begin
        if (wr_en) rows_q[wr_row] <= wr_data;
    end

    // Present the selected row.
    always_comb rd_data = rows_q[rd_row];
endmodule

// File: rtl/lane_mask_gen.sv
// Decides which output lanes carry converted data.
// A lane is live when its row is in range, its dword position lies inside the
// row, and that position is below the configured width in dwords.
module lane_mask_gen #(
    parameter int LANES   = 16,
    parameter int WIDTH_W = 7
) (
    input  logic [15:0]        chunk,
    input  logic [WIDTH_W-1:0] width,
    input  logic               row_ok,
    output logic [LANES-1:0]   live
);
    logic [31:0] base;
    logic [31:0] limit;

    // Clamp the width in dwords to the row size and derive the chunk base.
    always_comb begin
        base  = 32'(chunk) * 32'(LANES);
        limit = 32'(width >> 2);
        if (limit > 32'(LANES)) limit = 32'(LANES);
    end

    // Per-lane compare of the dword position against the limit.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            live[i] = row_ok && ((base + 32'(i)) < limit);
        end
    end
endmodule

// File: rtl/i2f_lane.sv
// Signed 32-bit integer to fp32 conversion, round to nearest, ties to even.
// Purely combinational; raises no flags and takes no rounding mode input.
module i2f_lane
    import tile_cvt_pkg::*;
(
    input  dword_t din,
    output dword_t dout
);
    logic        sgn;
    logic [31:0] mag;
    logic [4:0]  lead;
    logic [31:0] norm;
    logic [23:0] man;
    logic        rnd_up;
    logic [24:0] sum;
    logic [7:0]  expo;

    // Magnitude and position of its leading one.
    always_comb begin
        sgn  = din[31];
        mag  = sgn ? (~din + 32'd1) : din;
        lead = '0;
        for (int k = 0; k < 32; k++) begin
            if (mag[k]) lead = 5'(k);
        end
    end

    // Normalise, round on guard and sticky bits, pack the result.
    always_comb begin
        norm   = mag << (5'd31 - lead);
        man    = norm[31:8];
        rnd_up = norm[7] & ((|norm[6:0]) | man[0]);
        sum    = {1'b0, man} + {24'd0, rnd_up};
        expo   = 8'd127 + {3'd0, lead} + {7'd0, sum[24]};
        if (mag == 32'd0) dout = '0;
        else              dout = {sgn, expo, sum[22:0]};
    end
endmodule

// File: rtl/tile_row_i2f.sv
// Tile row integer-to-float converter, top level.
// Holds the tile and width register, decodes the selector, converts sixteen
// lanes in parallel and registers the result one cycle after a request.
// Assumes ROW_BYTES is a multiple of 4 and ROWS is a power of two.
module tile_row_i2f
    import tile_cvt_pkg::*;
#(
    parameter int ROWS      = 16,
    parameter int ROW_BYTES = 64,
    localparam int LANES    = ROW_BYTES / 4,
    localparam int ROW_W    = $clog2(ROWS),
    localparam int DATA_W   = ROW_BYTES * 8,
    localparam int WIDTH_W  = $clog2(ROW_BYTES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ROW_W-1:0]   wr_row,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               cfg_we,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic               req_valid,
    input  logic [31:0]        req_sel,
    output logic               res_valid,
    output logic [DATA_W-1:0]  res_data
);
    sel_t               sel;
    logic               row_ok;
    logic [WIDTH_W-1:0] width_q;
    logic [DATA_W-1:0]  row_data;
    logic [DATA_W-1:0]  cvt_data;
    logic [DATA_W-1:0]  next_data;
    logic [LANES-1:0]   live;

    // Split the selector and range-check the row index.
    always_comb begin
        sel    = sel_t'(req_sel);
        row_ok = sel.row < 16'(ROWS);
    end

    // Active width register, full row after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      width_q <= WIDTH_W'(ROW_BYTES);
        else if (cfg_we) width_q <= cfg_width;
    end

    tile_row_store #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .rd_row  (sel.row[ROW_W-1:0]),
        .rd_data (row_data)
    );

    lane_mask_gen #(.LANES(LANES), .WIDTH_W(WIDTH_W)) u_mask (
        .chunk  (sel.chunk),
        .width  (width_q),
        .row_ok (row_ok),
        .live   (live)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        i2f_lane u_cvt (
            .din  (row_data[i*DW +: DW]),
            .dout (cvt_data[i*DW +: DW])
        );
        assign next_data[i*DW +: DW] = live[i] ? cvt_data[i*DW +: DW] : '0;
    end

    // Result register and strobe; data holds between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) res_data <= next_data;
        end
    end
endmodule

// File: rtl/tile_row_i2f_chk.sv
// Protocol and masking checker for tile_row_i2f, attached by bind.
module tile_row_i2f_chk #(
    parameter int LANES   = 16,
    parameter int WIDTH_W = 7,
    parameter int ROWS    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [31:0]        req_sel,
    input logic               res_valid,
    input logic [LANES*32-1:0] res_data,
    input logic [WIDTH_W-1:0] width_q
);
    // R2: strobe follows a request by one cycle.
    p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    // R2: no strobe without a request.
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    // R2: data holds when no request was made.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(res_data));
    // R3: rows past the tile read as zero.
    p_far_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_sel[15:0] >= 16'(ROWS))) |=> (res_data == '0));
    // R4: any nonzero chunk lies outside the row.
    p_chunk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_sel[31:16] != 16'd0)) |=> (res_data == '0));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // R5: lanes at or past the width in dwords are zero.
        p_lane_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && ((32'(req_sel[31:16]) * 32'(LANES) + 32'(i)) >= 32'(width_q >> 2)))
            |=> (res_data[i*32 +: 32] == 32'd0));
    end
endmodule

bind tile_row_i2f tile_row_i2f_chk #(.LANES(LANES), .WIDTH_W(WIDTH_W), .ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_sel   (req_sel),
    .res_valid (res_valid),
    .res_data  (res_data),
    .width_q   (width_q)
);

// File: tb/sim_tile_row_i2f.sv
// Sweep bench for tile_row_i2f: every row index, several chunks and widths.
module sim_tile_row_i2f;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_row = '0;
    logic [511:0] wr_data = '0;
    logic         cfg_we = 1'b0;
    logic [6:0]   cfg_width = '0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_sel = '0;
    logic         res_valid;
    logic [511:0] res_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;
    logic [31:0] mdl [16][16];
    int cur_width = 64;

    always #4 clk = ~clk;

    tile_row_i2f u0 (.*);

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Reference conversion by integer division and remainder.
    function automatic logic [31:0] ref_f32(input logic [31:0] v);
        longint a, q, r, half, frac, p;
        int e;
        logic s;
        s = v[31];
        a = s ? (64'h1_0000_0000 - longint'(v)) : longint'(v);
        if (a == 0) return 32'd0;
        e = 0;
        while ((64'd1 << (e + 1)) <= a) e++;
        if (e <= 23) begin
            frac = (a << (23 - e)) - (64'd1 << 23);
        end else begin
            p = 64'd1 << (e - 23);
            q = a / p;
            r = a % p;
            half = p / 2;
            if (r > half || (r == half && (q % 2) == 1)) q++;
            if (q == (64'd1 << 24)) begin
                q = 64'd1 << 23;
                e++;
            end
            frac = q - (64'd1 << 23);
        end
        return {s, 8'(e + 127), 23'(frac)};
    endfunction

    function automatic logic [511:0] exp_vec(input int row, input int chunk, input int width);
        logic [511:0] x;
        int lim;
        x = '0;
        lim = width / 4;
        if (lim > 16) lim = 16;
        for (int i = 0; i < 16; i++) begin
            if (row < 16 && (chunk * 16 + i) < lim) x[i*32 +: 32] = ref_f32(mdl[row][i]);
        end
        return x;
    endfunction

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic write_row(input int row);
        @(negedge clk);
        wr_en = 1'b1;
        wr_row = 4'(row);
        for (int i = 0; i < 16; i++) wr_data[i*32 +: 32] = mdl[row][i];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_width(input int w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_width = 7'(w);
        @(negedge clk);
        cfg_we = 1'b0;
        cur_width = (w > 127) ? 127 : w;
    endtask

    // Issue one request; sample the result at the following falling edge.
    task automatic do_req(input int row, input int chunk, input string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_sel = {16'(chunk), 16'(row)};
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " strobe R2"}, 512'(res_valid), 512'(1));
        check(req, res_data, exp_vec(row, chunk, cur_width));
    endtask

    initial begin
        logic [511:0] held;
        int widths[8] = '{64, 0, 3, 4, 5, 32, 63, 100};
        int chunks[3] = '{0, 1, 65535};
        // Tile contents: row 0 holds the special values, others a spread pattern.
        for (int r = 0; r < 16; r++)
            for (int i = 0; i < 16; i++)
                mdl[r][i] = ((32'(r) * 32'h9E3779B9) ^ (32'(i) * 32'h7F4A7C15)) >>> (i % 9);
        mdl[0][0] = 32'd0;
        mdl[0][1] = 32'h8000_0000;
        mdl[0][2] = 32'h7FFF_FFFF;
        mdl[0][3] = 32'd16777217;
        mdl[0][4] = 32'd16777219;
        mdl[0][5] = 32'd1;
        mdl[0][6] = 32'hFFFF_FFFF;
        mdl[0][7] = 32'd16777216;
        mdl[0][8] = 32'hFF00_0001;

        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 reset strobe", 512'(res_valid), 512'(0));
        check("R1 reset data", res_data, '0);
        rst_n = 1'b1;

        // R8: load all rows.
        for (int r = 0; r < 16; r++) write_row(r);

        // R1: width after reset is 64, all lanes live.
        do_req(0, 0, "R1 R6 reset width");
        // R7: literal encodings of the special values.
        check("R7 zero", 512'(res_data[0 +: 32]), 512'(32'h0000_0000));
        check("R7 min int", 512'(res_data[32 +: 32]), 512'(32'hCF00_0000));
        check("R7 max int", 512'(res_data[64 +: 32]), 512'(32'h4F00_0000));
        check("R7 tie even down", 512'(res_data[96 +: 32]), 512'(32'h4B80_0000));
        check("R7 tie even up", 512'(res_data[128 +: 32]), 512'(32'h4B80_0002));
        check("R6 one", 512'(res_data[160 +: 32]), 512'(32'h3F80_0000));
        check("R6 minus one", 512'(res_data[192 +: 32]), 512'(32'hBF80_0000));

        // R2: no request keeps the data and drops the strobe.
        held = res_data;
        @(negedge clk);
        check("R2 idle strobe", 512'(res_valid), 512'(0));
        check("R2 hold data", res_data, held);

        // R3 R4 R5 R6: sweep widths, rows and chunks.
        foreach (widths[w]) begin
            set_width(widths[w]);
            for (int r = 0; r < 19; r++)
                foreach (chunks[c])
                    do_req((r == 18) ? 65535 : r, chunks[c], "R3 R4 R5 R6 R9 sweep");
        end

        // R9: request in the cycle of a width load uses the old width.
        set_width(64);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_width = 7'd8;
        req_valid = 1'b1;
        req_sel = 32'd3;
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b0;
        check("R9 old width", res_data, exp_vec(3, 0, 64));
        cur_width = 8;
        do_req(3, 0, "R9 new width");

        // R8: overwrite a row and read it back.
        set_width(64);
        for (int i = 0; i < 16; i++) mdl[5][i] = 32'(i) * 32'h0101_0101 - 32'd7;
        write_row(5);
        do_req(5, 0, "R8 rewrite");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule